// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core. The sources are two external request pins (active low), two timer overflow lines and one serial-port request. Each external pin can be set to level or falling-edge sensing. A per-source mask register places each source in either the high or the low priority level. A source takes part in arbitration only when its own enable bit and the global enable bit are both set.

The core signals the end of each instruction with a one-cycle strobe. On that strobe the controller may accept the winning request. One cycle later it raises a one-cycle acknowledge and presents the 16-bit service address. It keeps one in-service flag per level. These flags allow a high-priority service to interrupt a low-priority one, but never the reverse. The core's return strobe retires the most urgent active level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When eligible requests exist at both levels, the high-level request is accepted first.
- R2: Within one level, the winner is the lowest source index. Index 0 is external 0, 1 is timer 0, 2 is external 1, 3 is timer 1 and 4 is serial. Bit i of every mask port refers to source i.
- R3: While only a low-level service is active, a high-level request is accepted, so both in-service flags are set. A low-level request is not accepted while a low-level service is active.
- R4: While a high-level service is active, no request is accepted.
- R5: A request is accepted only in a cycle in which `insn_done` is 1. `ack` is 1 for exactly the following cycle, and the vector is valid at that time.
- R6: In edge mode (`ext_edge_mode[k]`=1), a 1-then-0 on successive samples of the pin latches a request. The request stays latched after the pin returns high. It is cleared when that source is accepted. A pin held low yields only one acceptance.
- R7: The vector is 0003H + 8 × index, giving 0003H, 000BH, 0013H, 001BH and 0023H.
- R8: A source with a clear enable bit, or any source while `glb_en` is 0, is never accepted.
- R9: `ret_pulse` clears `in_svc_hi` when that flag is set. Otherwise it clears `in_svc_lo`.
- R10: In level mode, a pin held low is a request. A pin that goes high again before the instruction boundary leaves no request.
- R11: After reset, `ack`, `vec_addr`, `in_svc_lo` and `in_svc_hi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge_mode | input | 2 | Per pin: 1 = falling edge, 0 = low level |
| tmr_ovf | input | 2 | Timer 0/1 overflow requests |
| ser_req | input | 1 | Serial-port request |
| glb_en | input | 1 | Global enable |
| en_mask | input | 5 | Per-source enable |
| hi_mask | input | 5 | Per-source high-priority select |
| insn_done | input | 1 | Instruction boundary strobe |
| ret_pulse | input | 1 | Return-from-service strobe |
| ack | output | 1 | One-cycle acceptance pulse |
| vec_addr | output | 16 | Service address of the last accepted source |
| in_svc_lo | output | 1 | Low-level service active |
| in_svc_hi | output | 1 | High-level service active |

## Verification
The assertions check on every cycle that acceptance follows an instruction boundary and a set global enable, and that nothing is accepted under an active high-level service. They also check that a low-level service never starts beneath a high one, that a return leaves the low flag alone while the high flag is set, and that every vector is one of the five legal addresses. Only the bench scenarios can show which source wins. They sweep every request pattern and every priority mask, and cover pre-emption order, the edge latch surviving a released pin and clearing on acceptance, and the masking of disabled sources.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_pin_n,
  input  logic [1:0]  ext_edge_mode,
  input  logic [1:0]  tmr_ovf,
  input  logic        ser_req,
  input  logic        glb_en,
  input  logic [4:0]  en_mask,
  input  logic [4:0]  hi_mask,
  input  logic        insn_done,
  input  logic        ret_pulse,
  output logic        ack,
  output logic [15:0] vec_addr,
  output logic        in_svc_lo,
  output logic        in_svc_hi
);
  localparam int NSRC = 5;

  logic [1:0]      pin_prev, edge_flag, ext_req, fall;
  logic [NSRC-1:0] pend, elig, hi_c, lo_c;
  logic            take_hi, take_lo, take;
  logic [2:0]      hi_idx, lo_idx, win_idx;

  function automatic logic [2:0] first_set(input logic [NSRC-1:0] v);
    logic [2:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = 3'(i);
    return r;
  endfunction

  assign fall    = pin_prev & ~ext_pin_n;
  assign ext_req = (ext_edge_mode & edge_flag) | (~ext_edge_mode & ~ext_pin_n);
  assign pend    = {ser_req, tmr_ovf[1], ext_req[1], tmr_ovf[0], ext_req[0]};
  assign elig    = pend & en_mask & {NSRC{glb_en}};
  assign hi_c    = elig & hi_mask;
  assign lo_c    = elig & ~hi_mask;
  assign hi_idx  = first_set(hi_c);
  assign lo_idx  = first_set(lo_c);

  assign take_hi = insn_done & (|hi_c) & ~in_svc_hi;
  assign take_lo = insn_done & (|lo_c) & ~(|hi_c) & ~in_svc_hi & ~in_svc_lo;
  assign take    = take_hi | take_lo;
  assign win_idx = take_hi ? hi_idx : lo_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev  <= 2'b11;
      edge_flag <= 2'b00;
    end else begin
      pin_prev <= ext_pin_n;
      for (int k = 0; k < 2; k++)
        edge_flag[k] <= fall[k] | (edge_flag[k] & ~(take && win_idx == 3'(2 * k)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack       <= 1'b0;
      vec_addr  <= '0;
      in_svc_lo <= 1'b0;
      in_svc_hi <= 1'b0;
    end else begin
      ack       <= take;
      if (take) vec_addr <= 16'(int'(VEC_BASE) + VEC_STEP * int'(win_idx));
      in_svc_hi <= (in_svc_hi & ~ret_pulse) | take_hi;
      in_svc_lo <= (in_svc_lo & ~(ret_pulse & ~in_svc_hi)) | take_lo;
    end
  end

  p_ack_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(insn_done));
  p_ack_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(glb_en));
  p_hi_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_hi && !ret_pulse) |=> !ack);
  p_lo_under_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_svc_lo) |-> !$past(in_svc_hi));
  p_ret_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pulse && in_svc_hi) |=> (in_svc_lo == $past(in_svc_lo)));
  p_vec_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vec_addr[2:0] == 3'd3 && vec_addr <= 16'h0023));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ext_pin_n = 2'b11, ext_edge_mode = 2'b00, tmr_ovf = 2'b00;
  logic ser_req = 1'b0, glb_en = 1'b1, insn_done = 1'b0, ret_pulse = 1'b0;
  logic [4:0] en_mask = 5'h1f, hi_mask = 5'h00;
  logic ack, in_svc_lo, in_svc_hi;
  logic [15:0] vec_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n),
    .ext_edge_mode(ext_edge_mode), .tmr_ovf(tmr_ovf), .ser_req(ser_req),
    .glb_en(glb_en), .en_mask(en_mask), .hi_mask(hi_mask), .insn_done(insn_done),
    .ret_pulse(ret_pulse), .ack(ack), .vec_addr(vec_addr),
    .in_svc_lo(in_svc_lo), .in_svc_hi(in_svc_hi));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_req(input logic [4:0] m);
    ext_pin_n[0] = ~m[0]; tmr_ovf[0] = m[1]; ext_pin_n[1] = ~m[2];
    tmr_ovf[1] = m[3]; ser_req = m[4];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; drive_req(5'h00); ext_edge_mode = 2'b00; hi_mask = '0;
    en_mask = 5'h1f; glb_en = 1'b1; insn_done = 1'b0; ret_pulse = 1'b0;
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic boundary();
    insn_done = 1'b1; @(negedge clk); insn_done = 1'b0;
  endtask

  task automatic do_ret();
    ret_pulse = 1'b1; @(negedge clk); ret_pulse = 1'b0;
  endtask

  function automatic logic [15:0] vec_of(input logic [4:0] m);
    for (int i = 0; i < 5; i++)
      if (m[i]) return 16'(3 + 8 * i);
    return 16'h0;
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R11 ack", ack, 0); check("R11 vec", vec_addr, 0);
    check("R11 lo", in_svc_lo, 0); check("R11 hi", in_svc_hi, 0);
    rst_n = 1'b1; @(negedge clk);

    // R2 R7: every request pattern, all low level
    for (int m = 1; m < 32; m++) begin
      drive_req(5'(m)); @(negedge clk);
      boundary();
      check("R2 ack", ack, 1); check("R7 vec", vec_addr, vec_of(5'(m)));
      check("R2 lo", in_svc_lo, 1);
      drive_req(5'h00); do_ret();
      check("R9 lo cleared", in_svc_lo, 0);
    end

    // R1: all requesting, every priority mask
    for (int h = 1; h < 32; h++) begin
      do_reset();
      hi_mask = 5'(h); drive_req(5'h1f); @(negedge clk);
      boundary();
      check("R1 vec", vec_addr, vec_of(5'(h)));
      check("R1 hi", in_svc_hi, 1); check("R1 lo", in_svc_lo, 0);
    end

    // R3 R4 R9: nesting
    do_reset();
    hi_mask = 5'b00110;
    drive_req(5'b00001); @(negedge clk); boundary();
    check("R3 lo vec", vec_addr, 16'h0003);
    drive_req(5'b01001); @(negedge clk); boundary();
    check("R3 lo no preempt", ack, 0); check("R3 lo flag", in_svc_lo, 1);
    drive_req(5'b01011); @(negedge clk); boundary();
    check("R3 preempt ack", ack, 1); check("R3 preempt vec", vec_addr, 16'h000B);
    check("R3 both hi", in_svc_hi, 1); check("R3 both lo", in_svc_lo, 1);
    drive_req(5'b01101); @(negedge clk); boundary();
    check("R4 blocked", ack, 0); check("R4 vec held", vec_addr, 16'h000B);
    do_ret();
    check("R9 hi cleared", in_svc_hi, 0); check("R9 lo kept", in_svc_lo, 1);
    boundary();
    check("R3 second hi", vec_addr, 16'h0013); check("R3 second hi ack", ack, 1);
    drive_req(5'h00); do_ret(); do_ret();
    check("R9 all clear", {in_svc_hi, in_svc_lo}, 0);

    // R5
    do_reset();
    tmr_ovf[0] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); check("R5 no boundary", ack, 0);
    end
    boundary();
    check("R5 ack", ack, 1); check("R5 vec", vec_addr, 16'h000B);
    @(negedge clk); check("R5 one cycle", ack, 0);

    // R8
    do_reset();
    glb_en = 1'b0; drive_req(5'h1f); @(negedge clk); boundary();
    check("R8 global off", ack, 0);
    glb_en = 1'b1; en_mask = 5'b10000; drive_req(5'b01111); @(negedge clk); boundary();
    check("R8 source off", ack, 0);
    drive_req(5'b11111); @(negedge clk); boundary();
    check("R8 only enabled", vec_addr, 16'h0023);

    // R6
    do_reset();
    ext_edge_mode = 2'b11;
    ext_pin_n[0] = 1'b0; @(negedge clk); ext_pin_n[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    boundary();
    check("R6 latched", ack, 1); check("R6 vec", vec_addr, 16'h0003);
    do_ret(); boundary();
    check("R6 cleared", ack, 0);
    ext_pin_n[1] = 1'b0;
    for (int c = 0; c < 3; c++) @(negedge clk);
    boundary(); check("R6 held low", vec_addr, 16'h0013);
    do_ret(); boundary();
    check("R6 single", ack, 0);

    // R10
    do_reset();
    ext_pin_n[1] = 1'b0; @(negedge clk); ext_pin_n[1] = 1'b1; @(negedge clk);
    boundary(); check("R10 released", ack, 0);
    ext_pin_n[1] = 1'b0; @(negedge clk); boundary();
    check("R10 level", vec_addr, 16'h0013);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule